// File: doc/BRIEF.md
# Floating-Point Gain Barrel Scaler

This block scales a signed fixed-point sample ahead of a decimating filter. The gain has two parts. The first is a floating-point value: a 4-bit mantissa fraction with an implied leading one, times two raised to a 3-bit exponent. The second is an independent programmable left shift of up to 63 places. A fixed attenuation of 2^-36 is folded in so that the worst-case growth of the following filter cannot overflow it. The mantissa and exponent come from an external gain loop as registered inputs. The shift is a static configuration value.

The input is a 12-bit two's-complement fraction with its LSB weighted 2^-11. The output is a 55-bit two's-complement word with its sign bit weighted -2^8 and its LSB weighted 2^-46, which matches the filter input window. The exponent and the shift are added to form one total shift, so a single barrel shifter serves both. Results outside the window are clamped to the nearest end, and a sticky flag records that a clamp happened. The datapath has two register stages, and the valid qualifier travels alongside the data.

Top module: `gsc_gain_scaler`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `out_valid`, `out_data` and `ovf_flag` are all zero.
- R2: `out_valid` repeats `in_valid` exactly two clock edges later.
- R3: For an accepted sample x (a signed integer), mantissa field m and total t = exponent + shift, `out_data` equals floor(x * (16 + m) * 2^(t - 5)). This is the signed 55-bit integer result whenever it lies in the output window.
- R4: A result above 2^54 - 1 drives `out_data` to 0x3F_FFFF_FFFF_FFFF, the largest positive 55-bit value.
- R5: A result below -2^54 drives `out_data` to 0x40_0000_0000_0000, the most negative 55-bit value. A result of exactly -2^54 passes through unclamped.
- R6: `ovf_flag` rises in the same cycle as the first clamped output. It stays high until reset, and it never rises for an output that was not clamped.
- R7: While `out_valid` is low, `out_data` holds its last value, whatever the inputs do.
- R8: Only the sum of the exponent and the shift matters. Any split with the same total gives the same output.
- R9: When the total shift is below 5, the low bits are discarded by an arithmetic right shift, which rounds toward negative infinity (for example, x = -1 with m = 0 and t = 0 gives -1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | 12 | Signed input sample, LSB weight 2^-11 |
| agc_mant | input | 4 | Mantissa fraction, value 1 + m/16 |
| agc_exp | input | 3 | Adaptive exponent, 0 to 7 |
| cic_shift | input | 6 | Programmable shift, 0 to 63 |
| out_valid | output | 1 | Result qualifier |
| out_data | output | 55 | Signed scaled result, LSB weight 2^-46 |
| ovf_flag | output | 1 | Sticky clamp indicator |

## Verification
The bench builds the block with its default parameters: a 12-bit input, a 4-bit mantissa, a 3-bit exponent, a 6-bit shift, a 55-bit output and an attenuation of 36. With these values the total shift runs from 0 to 70. That range reaches three regions: the truncating downshift below a total of 5, the exact negative boundary at a total of 44, and the clamps at both ends of the window. The bench also uses totals that are split differently between the exponent and the shift, and it changes the inputs while the valid qualifier is low.

// File: rtl/gsc_pkg.sv
// Package: default geometry of the gain scaler.
// Assumes the input and output are two's-complement fixed-point words.
package gsc_pkg;
    localparam int GSC_IN_W     = 12;  // input sample width
    localparam int GSC_IN_FRAC  = 11;  // fractional bits of the input
    localparam int GSC_MANT_FW  = 4;   // mantissa fraction bits
    localparam int GSC_EXP_W    = 3;   // exponent field width
    localparam int GSC_SHF_W    = 6;   // programmable shift width
    localparam int GSC_OUT_W    = 55;  // output width
    localparam int GSC_OUT_FRAC = 46;  // fractional bits of the output
    localparam int GSC_ATTEN    = 36;  // fixed attenuation, power of two
endpackage

// File: rtl/gsc_prep.sv
// Module: gsc_prep
// Multiplies the sample by the mantissa (with its implied leading one) and
// adds the exponent to the programmable shift to form one total shift.
// Assumes: the mantissa field is an unsigned fraction; the sample is signed.
module gsc_prep #(
    parameter int IN_W    = 12,
    parameter int MANT_FW = 4,
    parameter int EXP_W   = 3,
    parameter int SHF_W   = 6,
    parameter int PROD_W  = 18,
    parameter int TOT_W   = 7
) (
    input  logic [IN_W-1:0]          sample,
    input  logic [MANT_FW-1:0]       mant,
    input  logic [EXP_W-1:0]         expo,
    input  logic [SHF_W-1:0]         shift,
    output logic signed [PROD_W-1:0] prod,
    output logic [TOT_W-1:0]         total
);
    logic signed [PROD_W-1:0] op_a;
    logic signed [PROD_W-1:0] op_b;

    // Sign-extend the sample and zero-extend the mantissa with its hidden one, then multiply.
    always_comb begin
        op_a = PROD_W'($signed(sample));
        op_b = PROD_W'({2'b01, mant});
        prod = op_a * op_b;
    end

    // Combine the two gain exponents into one shift amount.
    always_comb begin
        total = TOT_W'(expo) + TOT_W'(shift);
    end
endmodule

// File: rtl/gsc_shift_sat.sv
// Module: gsc_shift_sat
// Shifts the product left by the total, drops DROP low bits arithmetically,
// and clamps the result to an OUT_W-bit signed window.
// Assumes: DROP >= 0 and WIDE_W is large enough to hold the full left shift.
module gsc_shift_sat #(
    parameter int PROD_W = 18,
    parameter int TOT_W  = 7,
    parameter int WIDE_W = 88,
    parameter int OUT_W  = 55,
    parameter int DROP   = 5
) (
    input  logic signed [PROD_W-1:0] prod,
    input  logic [TOT_W-1:0]         total,
    output logic [OUT_W-1:0]         result,
    output logic                     clamped
);
    localparam int HI_W = WIDE_W - OUT_W + 1;

    logic signed [WIDE_W-1:0] widened;
    logic signed [WIDE_W-1:0] moved;
    logic [HI_W-1:0]          top_bits;
    logic                     fits;

    // Widen the product, then apply the left shift and the fixed downshift.
    always_comb begin
        widened = WIDE_W'(prod);
        moved   = (widened <<< total) >>> DROP;
    end

    // The value fits when every bit above the output sign matches that sign.
    always_comb begin
        top_bits = moved[WIDE_W-1:OUT_W-1];
        fits     = (top_bits == '0) || (top_bits == '1);
    end

    // Pass the value through, or clamp it to the end of the window on its side.
    always_comb begin
        clamped = !fits;
        if (fits) begin
            result = moved[OUT_W-1:0];
        end else if (moved[WIDE_W-1]) begin
            result = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            result = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/gsc_gain_scaler.sv
// Module: gsc_gain_scaler
// Two-stage gain scaler. Stage 1 registers the mantissa product and the
// total shift. Stage 2 registers the shifted, clamped word and keeps a
// sticky clamp flag.
// Assumes: the gain inputs are stable while in_valid is high; reset is
// synchronous and active low.
module gsc_gain_scaler #(
    parameter int IN_W     = gsc_pkg::GSC_IN_W,
    parameter int IN_FRAC  = gsc_pkg::GSC_IN_FRAC,
    parameter int MANT_FW  = gsc_pkg::GSC_MANT_FW,
    parameter int EXP_W    = gsc_pkg::GSC_EXP_W,
    parameter int SHF_W    = gsc_pkg::GSC_SHF_W,
    parameter int OUT_W    = gsc_pkg::GSC_OUT_W,
    parameter int OUT_FRAC = gsc_pkg::GSC_OUT_FRAC,
    parameter int ATTEN    = gsc_pkg::GSC_ATTEN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [IN_W-1:0]    in_sample,
    input  logic [MANT_FW-1:0] agc_mant,
    input  logic [EXP_W-1:0]   agc_exp,
    input  logic [SHF_W-1:0]   cic_shift,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_data,
    output logic               ovf_flag
);
    localparam int PROD_W  = IN_W + MANT_FW + 2;
    localparam int TOT_MAX = (2 ** EXP_W - 1) + (2 ** SHF_W - 1);
    localparam int TOT_W   = $clog2(TOT_MAX + 1);
    localparam int WIDE_W  = PROD_W + TOT_MAX;
    localparam int DROP    = IN_FRAC + MANT_FW + ATTEN - OUT_FRAC;

    logic signed [PROD_W-1:0] prep_prod;
    logic [TOT_W-1:0]         prep_total;
    logic                     s1_valid;
    logic signed [PROD_W-1:0] s1_prod;
    logic [TOT_W-1:0]         s1_total;
    logic [OUT_W-1:0]         sat_data;
    logic                     sat_hit;

    gsc_prep #(
        .IN_W(IN_W), .MANT_FW(MANT_FW), .EXP_W(EXP_W), .SHF_W(SHF_W),
        .PROD_W(PROD_W), .TOT_W(TOT_W)
    ) u_prep (
        .sample(in_sample),
        .mant(agc_mant),
        .expo(agc_exp),
        .shift(cic_shift),
        .prod(prep_prod),
        .total(prep_total)
    );

    // Stage 1: capture the product and the total shift of an accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_prod  <= '0;
            s1_total <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_prod  <= prep_prod;
                s1_total <= prep_total;
            end
        end
    end

    gsc_shift_sat #(
        .PROD_W(PROD_W), .TOT_W(TOT_W), .WIDE_W(WIDE_W),
        .OUT_W(OUT_W), .DROP(DROP)
    ) u_shift (
        .prod(s1_prod),
        .total(s1_total),
        .result(sat_data),
        .clamped(sat_hit)
    );

    // Stage 2: register the clamped word and accumulate the sticky clamp flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            ovf_flag  <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_data <= sat_data;
                if (sat_hit) begin
                    ovf_flag <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/gsc_gain_scaler_chk.sv
// Module: gsc_gain_scaler_chk
// Temporal checks on the scaler ports, bound into every instance.
// Assumes: the same synchronous active-low reset as the scaler.
module gsc_gain_scaler_chk #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 55
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_sample,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data,
    input logic             ovf_flag
);
    logic [1:0] since_rst;

    // Count the edges since reset so that $past never reaches back into reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd2) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R2

    AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst == 2'd2) && $past(in_valid, 2) && ($past(in_sample, 2) == '0))
        |-> (out_data == '0)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag); // R6

    AST_OVF_RISE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> out_valid); // R6
endmodule

bind gsc_gain_scaler gsc_gain_scaler_chk #(
    .IN_W(IN_W), .OUT_W(OUT_W)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .in_valid(in_valid),
    .in_sample(in_sample),
    .out_valid(out_valid),
    .out_data(out_data),
    .ovf_flag(ovf_flag)
);

// File: tb/gsc_gain_scaler_test.sv
module gsc_gain_scaler_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_sample = '0;
    logic [3:0]  agc_mant = '0;
    logic [2:0]  agc_exp = '0;
    logic [5:0]  cic_shift = '0;
    logic        out_valid;
    logic [54:0] out_data;
    logic        ovf_flag;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  exp_ovf = 1'b0;
    bit  done = 1'b0;

    localparam logic [54:0] POS_MAX = {1'b0, {54{1'b1}}};
    localparam logic [54:0] NEG_MAX = {1'b1, {54{1'b0}}};

    always #2 clk = ~clk;

    gsc_gain_scaler uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .agc_mant(agc_mant), .agc_exp(agc_exp), .cic_shift(cic_shift),
        .out_valid(out_valid), .out_data(out_data), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected result built straight from the gain formula in R3, R4, R5 and R9.
    function automatic logic [54:0] model(input logic signed [11:0] x, input logic [3:0] m,
                                          input logic [2:0] e, input logic [5:0] s,
                                          output bit clip);
        logic signed [159:0] v;
        logic signed [159:0] lim;
        int mi;
        int t;
        v   = x;
        mi  = 16 + int'(m);
        v   = v * mi;
        t   = int'(e) + int'(s);
        if (t >= 5) v = v <<< (t - 5);
        else        v = v >>> (5 - t);
        lim = 160'sd1 <<< 54;
        clip = 1'b0;
        if (v >= lim)       begin clip = 1'b1; return POS_MAX; end
        else if (v < -lim)  begin clip = 1'b1; return NEG_MAX; end
        return v[54:0];
    endfunction

    // Sends one sample, checks the two-edge latency, the result and the sticky flag.
    task automatic run_one(input string req, input logic signed [11:0] x, input logic [3:0] m,
                           input logic [2:0] e, input logic [5:0] s,
                           output logic [54:0] got);
        bit clip;
        logic [54:0] exp_v;
        exp_v = model(x, m, e, s, clip);
        @(negedge clk);
        in_sample = x; agc_mant = m; agc_exp = e; cic_shift = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid low after one edge", 64'(out_valid), 64'd0);
        @(negedge clk);
        check("R2 valid high after two edges", 64'(out_valid), 64'd1);
        check(req, 64'(out_data), 64'(exp_v));
        if (clip) exp_ovf = 1'b1;
        check("R6 sticky flag", 64'(ovf_flag), 64'(exp_ovf));
        got = out_data;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_ovf = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", 64'(out_valid), 64'd0);
        check("R1 out_data after reset", 64'(out_data), 64'd0);
        check("R1 ovf_flag after reset", 64'(ovf_flag), 64'd0);
    endtask

    task automatic t_gain();
        logic [54:0] g;
        run_one("R3 gain pos", 12'sd100, 4'd5, 3'd2, 6'd10, g);
        run_one("R3 gain neg", -12'sd300, 4'd15, 3'd3, 6'd20, g);
        run_one("R3 gain full-scale", 12'sd2047, 4'd0, 3'd0, 6'd5, g);
        run_one("R3 gain minus one", -12'sd1, 4'd8, 3'd7, 6'd30, g);
        run_one("R3 gain mid", 12'sd1234, 4'd3, 3'd1, 6'd40, g);
        run_one("R3 gain zero", 12'sd0, 4'd15, 3'd7, 6'd63, g);
    endtask

    task automatic t_trunc();
        logic [54:0] g;
        run_one("R9 floor of -0.5", -12'sd1, 4'd0, 3'd0, 6'd0, g);
        check("R9 minus one all ones", 64'(g), 64'(55'h7F_FFFF_FFFF_FFFF));
        run_one("R9 floor of +0.5", 12'sd1, 4'd0, 3'd0, 6'd0, g);
        check("R9 plus half is zero", 64'(g), 64'd0);
        run_one("R9 partial downshift", -12'sd17, 4'd0, 3'd0, 6'd2, g);
    endtask

    task automatic t_sum();
        logic [54:0] a;
        logic [54:0] b;
        logic [54:0] c;
        run_one("R8 split 7+3", 12'sd555, 4'd9, 3'd7, 6'd3, a);
        run_one("R8 split 0+10", 12'sd555, 4'd9, 3'd0, 6'd10, b);
        run_one("R8 split 3+7", 12'sd555, 4'd9, 3'd3, 6'd7, c);
        check("R8 equal splits a b", 64'(a), 64'(b));
        check("R8 equal splits a c", 64'(a), 64'(c));
    endtask

    task automatic t_edge();
        logic [54:0] g;
        run_one("R5 exact negative limit", -12'sd2048, 4'd0, 3'd4, 6'd40, g);
        check("R5 exact limit not clamped", 64'(g), 64'(NEG_MAX));
        check("R6 no flag without clamp", 64'(ovf_flag), 64'd0);
    endtask

    task automatic t_hold();
        logic [54:0] g;
        run_one("R7 preload", 12'sd321, 4'd2, 3'd1, 6'd12, g);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_sample = 12'(k * 700 + 5); agc_mant = 4'(k); agc_exp = 3'(k); cic_shift = 6'(k * 9);
            check("R7 valid stays low", 64'(out_valid), 64'd0);
            check("R7 data held", 64'(out_data), 64'(g));
        end
    endtask

    task automatic t_sat_pos();
        logic [54:0] g;
        run_one("R4 first positive total over", 12'sd2047, 4'd15, 3'd4, 6'd40, g);
        check("R4 clamp value", 64'(g), 64'(POS_MAX));
        check("R6 flag rises with clamp", 64'(ovf_flag), 64'd1);
        run_one("R4 largest gain", 12'sd2047, 4'd15, 3'd7, 6'd63, g);
    endtask

    task automatic t_sticky();
        logic [54:0] g;
        run_one("R3 after clamp", 12'sd5, 4'd0, 3'd0, 6'd10, g);
        check("R6 flag stays set", 64'(ovf_flag), 64'd1);
    endtask

    task automatic t_sat_neg();
        logic [54:0] g;
        run_one("R5 negative clamp", -12'sd2048, 4'd15, 3'd7, 6'd63, g);
        check("R5 clamp value", 64'(g), 64'(NEG_MAX));
        run_one("R5 just past limit", -12'sd2048, 4'd1, 3'd4, 6'd40, g);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_gain();
        t_trunc();
        t_sum();
        t_edge();
        t_hold();
        t_sat_pos();
        t_sticky();
        t_sat_neg();
        t_reset();
        check("R6 flag cleared only by reset", 64'(ovf_flag), 64'd0);
        finish_run();
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end
endmodule